// File: doc/BRIEF.md
# Three-Level Vectored Interrupt Arbiter

This block sits between a set of peripheral request flags and a CPU core. Twenty-one request lines are folded onto ten vectors. Each vector has an enable bit and a one-bit level choice. The two lowest vectors choose between the top level and the bottom level. The other eight choose between the middle level and the bottom level.

Every cycle the block picks the best request among the enabled vectors that have something pending. It grants that request only if its level is strictly above the level currently in service. A grant is a one-cycle acknowledge pulse that carries the vector address. On a grant, the level that was in service is pushed onto a small stack, and the current level rises to the granted level.

A return input pops the stack and restores the previous level. A global enable of zero holds off every grant. Pending requests are not lost while grants are held off. Clearing the request flags is left to the peripherals.

Top module: `irq_arbiter`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `ack_o` is 0, `vec_addr_o` is 0x00 and `cur_level_o` is 0 (base level).
- R2: Request line s feeds vector s mod 10. For example, lines 0, 10 and 20 all feed vector 0. A vector v takes part in arbitration only when `vec_en[v]` is 1 and at least one of its lines is high.
- R3: Granting vector v drives `vec_addr_o` = 0x03 + 8·v in the same cycle as `ack_o`. This gives 0x03 up to 0x4B. The grant appears one clock edge after the request is sampled.
- R4: Level codes on `cur_level_o` are 0 = base, 1 = low, 2 = middle, 3 = top. When `lvl_sel[v]` = 0, vector v is low. When `lvl_sel[v]` = 1, vectors 0 and 1 are top and vectors 2 to 9 are middle.
- R5: A request is granted only if its level is strictly greater than `cur_level_o`. A request at an equal or lower level stays pending and is not acknowledged.
- R6: Among the competing vectors, the highest level wins. Among vectors at the same level, the lowest vector index wins.
- R7: On a grant, the previous level is pushed onto a 3-entry stack and `cur_level_o` takes the granted level. A `reti` pulse with a non-empty stack restores the most recently pushed level.
- R8: While `gie` is 0, no grant is issued. Requests that are still pending are granted once `gie` returns to 1.
- R9: In a cycle where `reti` is 1, no grant is issued. A `reti` with an empty stack leaves `cur_level_o` at 0.
- R10: Each acceptance gives exactly one `ack_o` pulse. A vector in service is not granted again while its request line stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 21 | Pending request flags from the peripherals |
| vec_en | input | 10 | Per-vector enable |
| lvl_sel | input | 10 | Per-vector level choice (1 = upper option) |
| gie | input | 1 | Global grant enable |
| reti | input | 1 | Return from interrupt, one-cycle pulse |
| ack_o | output | 1 | Grant pulse |
| vec_addr_o | output | 8 | Granted vector address, valid with ack_o |
| cur_level_o | output | 2 | Level currently in service |

## Verification
The bench builds the block with its default parameters: 21 lines, 10 vectors, 2 top-capable vectors, a 3-deep stack, and addresses starting at 0x03 with a step of 8. This setting makes every level reachable. It covers shared vectors that carry three lines, the wrap of line 20 onto vector 0, and a full base-to-top nesting that fills the stack. The walk back down through every stacked level can then be checked against an equal-level request that must stay blocked.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  typedef logic [1:0] lvl_t;
  localparam lvl_t LV_BASE = 2'd0;
  localparam lvl_t LV_LOW  = 2'd1;
  localparam lvl_t LV_MID  = 2'd2;
  localparam lvl_t LV_TOP  = 2'd3;
endpackage

// File: rtl/irq_vec_gather.sv
module irq_vec_gather
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC  = 21,
  parameter int NUM_VEC  = 10,
  parameter int NUM_XVEC = 2
) (
  input  logic [NUM_SRC-1:0]   src_req,
  input  logic [NUM_VEC-1:0]   vec_en,
  input  logic [NUM_VEC-1:0]   lvl_sel,
  output logic [NUM_VEC-1:0]   vec_pend,
  output logic [2*NUM_VEC-1:0] vec_lvl
);
  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    logic any_src;
    always_comb begin
      any_src = 1'b0;
      for (int s = 0; s < NUM_SRC; s++) begin
        if ((s % NUM_VEC) == v) any_src = any_src | src_req[s];
      end
    end
    assign vec_pend[v] = any_src & vec_en[v];

    if (v < NUM_XVEC) begin : g_top_capable
      assign vec_lvl[2*v +: 2] = lvl_sel[v] ? LV_TOP : LV_LOW;
    end else begin : g_mid_capable
      assign vec_lvl[2*v +: 2] = lvl_sel[v] ? LV_MID : LV_LOW;
    end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_arb_pkg::*;
#(
  parameter int NUM_VEC = 10,
  localparam int IDX_W  = $clog2(NUM_VEC)
) (
  input  logic [NUM_VEC-1:0]   vec_pend,
  input  logic [2*NUM_VEC-1:0] vec_lvl,
  input  lvl_t                 cur_level,
  output logic                 win_valid,
  output logic [IDX_W-1:0]     win_idx,
  output lvl_t                 win_lvl
);
  lvl_t best;
  lvl_t eff;
  always_comb begin
    best    = LV_BASE;
    win_idx = '0;
    eff     = LV_BASE;
    for (int v = 0; v < NUM_VEC; v++) begin
      eff = vec_pend[v] ? vec_lvl[2*v +: 2] : LV_BASE;
      // strict compare keeps the lowest index among equal levels
      if (eff > best) begin
        best    = eff;
        win_idx = IDX_W'(v);
      end
    end
    win_lvl   = best;
    win_valid = (best > cur_level);
  end
endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack
  import irq_arb_pkg::*;
#(
  parameter int DEPTH = 3,
  localparam int PTR_W = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic push,
  input  logic pop,
  input  lvl_t push_val,
  output lvl_t top_val,
  output logic empty
);
  lvl_t             mem [DEPTH];
  logic [PTR_W-1:0] ptr;

  always_ff @(posedge clk) begin
    if (push) mem[ptr[$clog2(DEPTH)-1:0]] <= push_val;
  end

  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (push) ptr <= ptr + 1'b1;
    else if (pop)  ptr <= ptr - 1'b1;
  end

  assign empty   = (ptr == '0);
  assign top_val = empty ? LV_BASE : mem[ptr[$clog2(DEPTH)-1:0] - 1'b1];

  // R7: the nesting rule never pushes past the stack depth
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    push |-> (ptr < PTR_W'(DEPTH)));
  // R9: the owner never pops an empty stack
  p_no_underflow_r9: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC   = 21,
  parameter int NUM_VEC   = 10,
  parameter int NUM_XVEC  = 2,
  parameter int STACK_DEP = 3,
  parameter int ADDR_W    = 8,
  parameter int VEC_BASE  = 3,
  parameter int VEC_STEP  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic [NUM_VEC-1:0] vec_en,
  input  logic [NUM_VEC-1:0] lvl_sel,
  input  logic               gie,
  input  logic               reti,
  output logic               ack_o,
  output logic [ADDR_W-1:0]  vec_addr_o,
  output logic [1:0]         cur_level_o
);
  localparam int IDX_W = $clog2(NUM_VEC);
  localparam logic [ADDR_W-1:0] ADDR_LAST = ADDR_W'(VEC_BASE + VEC_STEP * (NUM_VEC - 1));

  logic [NUM_VEC-1:0]   vec_pend;
  logic [2*NUM_VEC-1:0] vec_lvl;
  logic                 win_valid;
  logic [IDX_W-1:0]     win_idx;
  lvl_t                 win_lvl;
  lvl_t                 cur_level;
  lvl_t                 stk_top;
  logic                 stk_empty;
  logic                 grant;
  logic                 do_pop;
  logic [ADDR_W-1:0]    addr_next;

  irq_vec_gather #(.NUM_SRC(NUM_SRC), .NUM_VEC(NUM_VEC), .NUM_XVEC(NUM_XVEC)) u_gather (
    .src_req (src_req),
    .vec_en  (vec_en),
    .lvl_sel (lvl_sel),
    .vec_pend(vec_pend),
    .vec_lvl (vec_lvl)
  );

  irq_pick #(.NUM_VEC(NUM_VEC)) u_pick (
    .vec_pend (vec_pend),
    .vec_lvl  (vec_lvl),
    .cur_level(cur_level),
    .win_valid(win_valid),
    .win_idx  (win_idx),
    .win_lvl  (win_lvl)
  );

  assign grant     = gie & win_valid & ~reti;
  assign do_pop    = reti & ~stk_empty;
  assign addr_next = ADDR_W'(VEC_BASE) + ADDR_W'(VEC_STEP) * ADDR_W'(win_idx);

  irq_level_stack #(.DEPTH(STACK_DEP)) u_stack (
    .clk     (clk),
    .rst     (rst),
    .push    (grant),
    .pop     (do_pop),
    .push_val(cur_level),
    .top_val (stk_top),
    .empty   (stk_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_o      <= 1'b0;
      vec_addr_o <= '0;
      cur_level  <= LV_BASE;
    end else begin
      ack_o <= grant;
      if (grant) begin
        vec_addr_o <= addr_next;
        cur_level  <= win_lvl;
      end else if (do_pop) begin
        cur_level  <= stk_top;
      end
    end
  end

  assign cur_level_o = cur_level;

  // R8: a cleared global enable blocks the following grant
  p_gie_block_r8: assert property (@(posedge clk) disable iff (rst)
    !gie |=> !ack_o);
  // R5: each grant strictly raises the level in service
  p_raise_r5: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> (cur_level_o > $past(cur_level_o)));
  // R9: a return cycle issues no grant
  p_reti_block_r9: assert property (@(posedge clk) disable iff (rst)
    reti |=> !ack_o);
  // R7: a return from a nested level lowers the level
  p_pop_r7: assert property (@(posedge clk) disable iff (rst)
    (reti && cur_level_o != LV_BASE) |=> (cur_level_o < $past(cur_level_o)));
  // R3: a granted address lies in the vector window
  p_addr_r3: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> (vec_addr_o >= ADDR_W'(VEC_BASE) && vec_addr_o <= ADDR_LAST));
  // R10: the same vector is never acknowledged in back-to-back cycles
  p_single_r10: assert property (@(posedge clk) disable iff (rst)
    ack_o |=> !(ack_o && vec_addr_o == $past(vec_addr_o)));
endmodule

// File: tb/irq_arbiter_tb.sv
`timescale 1ns/1ps
module irq_arbiter_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [20:0] src_req = '0;
  logic [9:0]  vec_en = '1;
  logic [9:0]  lvl_sel = '0;
  logic        gie = 1'b1;
  logic        reti = 1'b0;
  logic        ack_o;
  logic [7:0]  vec_addr_o;
  logic [1:0]  cur_level_o;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  irq_arbiter u_dut (
    .clk(clk), .rst(rst), .src_req(src_req), .vec_en(vec_en), .lvl_sel(lvl_sel),
    .gie(gie), .reti(reti), .ack_o(ack_o), .vec_addr_o(vec_addr_o), .cur_level_o(cur_level_o)
  );

  typedef struct packed {
    logic [20:0] src;
    logic [9:0]  en;
    logic [9:0]  sel;
    logic        ack;
    logic [7:0]  addr;
    logic [1:0]  lvl;
  } row_t;

  localparam int N_ROWS = 10;
  localparam row_t TBL [N_ROWS] = '{
    '{21'h000001, 10'h3FF, 10'h000, 1'b1, 8'h03, 2'd1},  // R2 line 0 -> vec 0
    '{21'h100000, 10'h3FF, 10'h000, 1'b1, 8'h03, 2'd1},  // R2 line 20 wraps to vec 0
    '{21'h002000, 10'h3FF, 10'h000, 1'b1, 8'h1B, 2'd1},  // R3 line 13 -> vec 3
    '{21'h0000A0, 10'h3FF, 10'h000, 1'b1, 8'h2B, 2'd1},  // R6 tie, lower index
    '{21'h0000A0, 10'h3FF, 10'h080, 1'b1, 8'h3B, 2'd2},  // R6 middle beats low
    '{21'h000202, 10'h3FF, 10'h202, 1'b1, 8'h0B, 2'd3},  // R4 top beats middle
    '{21'h000210, 10'h1FF, 10'h000, 1'b1, 8'h23, 2'd1},  // R2 disabled vec 9 skipped
    '{21'h000200, 10'h1FF, 10'h000, 1'b0, 8'h00, 2'd0},  // R2 only disabled vector
    '{21'h000400, 10'h3FF, 10'h001, 1'b1, 8'h03, 2'd3},  // R4 vec 0 at top
    '{21'h001004, 10'h3FF, 10'h004, 1'b1, 8'h13, 2'd2}   // R2 two lines on vec 2
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; src_req = '0; reti = 1'b0; gie = 1'b1; vec_en = '1; lvl_sel = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset();
    check("R1 ack", ack_o, 0);
    check("R1 addr", vec_addr_o, 0);
    check("R1 level", cur_level_o, 0);

    // table walk
    for (int i = 0; i < N_ROWS; i++) begin
      do_reset();
      src_req = TBL[i].src; vec_en = TBL[i].en; lvl_sel = TBL[i].sel;
      step();
      check($sformatf("R3 row%0d ack", i), ack_o, TBL[i].ack);
      if (TBL[i].ack) check($sformatf("R6 row%0d addr", i), vec_addr_o, TBL[i].addr);
      check($sformatf("R4 row%0d level", i), cur_level_o, TBL[i].lvl);
      src_req = '0;
    end

    // nesting: low -> middle -> top, then unwind
    do_reset();
    lvl_sel = 10'h006;           // vec1 top, vec2 middle
    src_req = 21'h000008;        // line 3 -> vec3 low
    step();
    check("R7 low grant ack", ack_o, 1);
    check("R7 low grant addr", vec_addr_o, 8'h1B);
    check("R7 low level", cur_level_o, 1);
    step();
    check("R10 no regrant", ack_o, 0);
    src_req = 21'h00000C;        // add line 2 -> vec2 middle
    step();
    check("R7 mid grant addr", vec_addr_o, 8'h13);
    check("R7 mid level", cur_level_o, 2);
    src_req = 21'h00001C;        // add line 4 -> vec4 low
    step();
    check("R5 lower blocked", ack_o, 0);
    src_req = 21'h00001E;        // add line 1 -> vec1 top
    step();
    check("R7 top grant addr", vec_addr_o, 8'h0B);
    check("R7 top level", cur_level_o, 3);
    src_req = 21'h000010;        // only vec4 low left
    reti = 1'b1;
    step();
    check("R7 pop to mid", cur_level_o, 2);
    step();
    check("R7 pop to low", cur_level_o, 1);
    check("R9 no grant on return", ack_o, 0);
    reti = 1'b0;
    step();
    check("R5 equal level blocked", ack_o, 0);
    reti = 1'b1;
    step();
    reti = 1'b0;
    check("R7 pop to base", cur_level_o, 0);
    check("R9 return cycle blocks", ack_o, 0);
    step();
    check("R5 grant after unwind ack", ack_o, 1);
    check("R5 grant after unwind addr", vec_addr_o, 8'h23);

    // global enable
    do_reset();
    gie = 1'b0;
    src_req = 21'h000040;        // line 6 -> vec6
    for (int k = 0; k < 3; k++) begin
      step();
      check("R8 held off", ack_o, 0);
    end
    gie = 1'b1;
    step();
    check("R8 released ack", ack_o, 1);
    check("R8 released addr", vec_addr_o, 8'h33);

    // return with empty stack, with a request in the same cycle
    do_reset();
    reti = 1'b1;
    src_req = 21'h000100;        // line 8 -> vec8
    step();
    reti = 1'b0;
    check("R9 empty return level", cur_level_o, 0);
    check("R9 empty return no ack", ack_o, 0);
    step();
    check("R9 grant after return ack", ack_o, 1);
    check("R9 grant after return addr", vec_addr_o, 8'h43);
    src_req = '0;
    step();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule